// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block sits between the request path of a memory controller and its two independent 64-bit channels, A and B. It takes a flat byte-granular system physical address and decides which channel holds that byte and where inside that channel it lives. Software sets the capacity of each channel and selects a mapping mode. The capacity is a count of fixed-size units, 2^UNIT_SHIFT bytes each, which is 64 MB at the default setting.

There are three modes. The interleaved mode alternates channels on every 64-byte line. The linear mode fills channel A completely and then continues into channel B. The flexible mode interleaves a low zone twice the size of the smaller channel and maps what remains of the larger channel linearly above that zone. Addresses beyond the memory the mode can reach are flagged out of range and are given no channel.

The translation is combinational. A single output register stage with a valid/ready handshake on both sides holds the result.

Top module: `amap_top`

## Requirements
- R1: While reset is asserted and after its release, `rsp_valid` is 0, and `req_ready` is 1 while no result is held.
- R2: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request shows on the response outputs one clock later. A result that is not taken stays unchanged on the outputs.
- R3: Linear mode (`cfg_mode` = 2'b01):
  - An address below capacity A selects channel A with local address equal to the address.
  - An address from capacity A up to A+B selects channel B with local address equal to the address minus capacity A.
- R4: Interleaved mode (`cfg_mode` = 2'b00):
  - Addresses below twice the smaller capacity are interleaved. Address bit LINE_W = 1 selects B and 0 selects A.
  - The local address is the system address with bit LINE_W removed.
  - Addresses at or above twice the smaller capacity are out of range.
- R5: Flexible mode (`cfg_mode` = 2'b10) maps addresses below twice the smaller capacity exactly as R4 does.
- R6: In flexible mode, an address from twice the smaller capacity up to A+B selects the larger channel. Its local address is the address minus the smaller capacity.
- R7: In linear and flexible modes, an address at or above A+B raises `rsp_oor`, drives both selects to 0, and gives a local address of 0.
- R8: A capacity of zero on one channel is legal. In linear and flexible modes it maps every in-range address linearly into the other channel.
- R9: The reserved mode encoding 2'b11 flags every address out of range.
- R10: With `rsp_valid` high, at most one select is high, `rsp_oor` is high exactly when neither is, and the local address is below the capacity of the selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Mapping mode: 00 interleaved, 01 linear, 10 flexible, 11 reserved |
| cfg_cap_a | input | CAP_W | Capacity of channel A in units |
| cfg_cap_b | input | CAP_W | Capacity of channel B in units |
| req_valid | input | 1 | Request address is valid |
| req_ready | output | 1 | Mapper can take a request |
| req_addr | input | CAP_W+1+UNIT_SHIFT | System byte address |
| rsp_valid | output | 1 | Result is valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_sel_a | output | 1 | Result targets channel A |
| rsp_sel_b | output | 1 | Result targets channel B |
| rsp_oor | output | 1 | Address is out of range |
| rsp_local | output | CAP_W+UNIT_SHIFT | Byte address inside the selected channel |

## Verification
The bench builds the mapper with CAP_W = 2, UNIT_SHIFT = 7 and LINE_W = 6. This gives 128-byte units, 64-byte lines and a 1024-byte system space. At that size, every address can be swept under every pair of capacities from 0 to 3 units and under all four mode encodings. That sweep reaches the following cases:
- equal capacities;
- one empty channel and both channels empty;
- a larger A and a larger B;
- every zone boundary and the exact out-of-range edge.

A separate sequence stalls the response side to exercise holding a result and taking a queued request.

// File: rtl/amap_pkg.sv
package amap_pkg;
   typedef enum logic [1:0] {
      MAP_ILV  = 2'b00,
      MAP_LIN  = 2'b01,
      MAP_FLEX = 2'b10,
      MAP_RSVD = 2'b11
   } map_mode_e;
endpackage

// File: rtl/amap_zone_calc.sv
module amap_zone_calc #(
   parameter int CAP_W      = 9,
   parameter int UNIT_SHIFT = 26,
   localparam int ADDR_W    = CAP_W + 1 + UNIT_SHIFT
) (
   input  logic [CAP_W-1:0]  cap_a,
   input  logic [CAP_W-1:0]  cap_b,
   output logic [ADDR_W-1:0] a_bytes,
   output logic [ADDR_W-1:0] b_bytes,
   output logic [ADDR_W-1:0] min_bytes,
   output logic [ADDR_W-1:0] ilv_bytes,
   output logic [ADDR_W-1:0] sum_bytes,
   output logic              big_is_b
);
   logic [CAP_W-1:0] min_u;
   logic [CAP_W:0]   sum_u;

   always_comb begin
      big_is_b  = (cap_b > cap_a);
      min_u     = big_is_b ? cap_a : cap_b;
      sum_u     = {1'b0, cap_a} + {1'b0, cap_b};
      a_bytes   = {1'b0, cap_a, {UNIT_SHIFT{1'b0}}};
      b_bytes   = {1'b0, cap_b, {UNIT_SHIFT{1'b0}}};
      min_bytes = {1'b0, min_u, {UNIT_SHIFT{1'b0}}};
      ilv_bytes = {min_u, 1'b0, {UNIT_SHIFT{1'b0}}};
      sum_bytes = {sum_u, {UNIT_SHIFT{1'b0}}};
   end
endmodule

// File: rtl/amap_route.sv
module amap_route
   import amap_pkg::*;
#(
   parameter int CAP_W      = 9,
   parameter int UNIT_SHIFT = 26,
   parameter int LINE_W     = 6,
   localparam int ADDR_W    = CAP_W + 1 + UNIT_SHIFT,
   localparam int LOC_W     = CAP_W + UNIT_SHIFT
) (
   input  map_mode_e         mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] a_bytes,
   input  logic [ADDR_W-1:0] min_bytes,
   input  logic [ADDR_W-1:0] ilv_bytes,
   input  logic [ADDR_W-1:0] sum_bytes,
   input  logic              big_is_b,
   output logic              sel_a,
   output logic              sel_b,
   output logic              oor,
   output logic [LOC_W-1:0]  loc
);
   logic [LOC_W-1:0]  ilv_loc;
   logic              ilv_chan;
   logic [ADDR_W-1:0] lin_off;
   logic [ADDR_W-1:0] asym_off;

   // Drop the channel-select bit and close the gap it leaves.
   assign ilv_loc  = {addr[ADDR_W-1:LINE_W+1], addr[LINE_W-1:0]};
   assign ilv_chan = addr[LINE_W];
   assign lin_off  = addr - a_bytes;
   assign asym_off = addr - min_bytes;

   always_comb begin
      sel_a = 1'b0;
      sel_b = 1'b0;
      oor   = 1'b0;
      loc   = '0;
      unique case (mode)
         MAP_ILV: begin
            if (addr < ilv_bytes) begin
               sel_a = ~ilv_chan;
               sel_b = ilv_chan;
               loc   = ilv_loc;
            end else begin
               oor = 1'b1;
            end
         end
         MAP_LIN: begin
            if (addr >= sum_bytes) begin
               oor = 1'b1;
            end else if (addr < a_bytes) begin
               sel_a = 1'b1;
               loc   = addr[LOC_W-1:0];
            end else begin
               sel_b = 1'b1;
               loc   = lin_off[LOC_W-1:0];
            end
         end
         MAP_FLEX: begin
            if (addr >= sum_bytes) begin
               oor = 1'b1;
            end else if (addr < ilv_bytes) begin
               sel_a = ~ilv_chan;
               sel_b = ilv_chan;
               loc   = ilv_loc;
            end else begin
               sel_a = ~big_is_b;
               sel_b = big_is_b;
               loc   = asym_off[LOC_W-1:0];
            end
         end
         default: oor = 1'b1;
      endcase
   end
endmodule

// File: rtl/amap_out_stage.sv
module amap_out_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   assign in_ready = ~out_valid | out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));
   assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
endmodule

// File: rtl/amap_top.sv
module amap_top
   import amap_pkg::*;
#(
   parameter int CAP_W      = 9,
   parameter int UNIT_SHIFT = 26,
   parameter int LINE_W     = 6,
   localparam int ADDR_W    = CAP_W + 1 + UNIT_SHIFT,
   localparam int LOC_W     = CAP_W + UNIT_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic [CAP_W-1:0]  cfg_cap_a,
   input  logic [CAP_W-1:0]  cfg_cap_b,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_sel_a,
   output logic              rsp_sel_b,
   output logic              rsp_oor,
   output logic [LOC_W-1:0]  rsp_local
);
   localparam int PAY_W = LOC_W + 3;

   generate
      if (CAP_W < 1) begin : g_bad_cap
         $error("CAP_W must be at least 1");
      end
      if (LINE_W < 1) begin : g_bad_line
         $error("LINE_W must be at least 1");
      end
      if (LINE_W + 1 > UNIT_SHIFT) begin : g_bad_unit
         $error("a capacity unit must hold at least one line per channel");
      end
   endgenerate

   logic [ADDR_W-1:0] a_bytes, b_bytes, min_bytes, ilv_bytes, sum_bytes;
   logic              big_is_b;
   logic              c_sel_a, c_sel_b, c_oor;
   logic [LOC_W-1:0]  c_loc;
   logic [PAY_W-1:0]  pay_in, pay_out;

   amap_zone_calc #(.CAP_W(CAP_W), .UNIT_SHIFT(UNIT_SHIFT)) u_zone (
      .cap_a(cfg_cap_a), .cap_b(cfg_cap_b),
      .a_bytes(a_bytes), .b_bytes(b_bytes), .min_bytes(min_bytes),
      .ilv_bytes(ilv_bytes), .sum_bytes(sum_bytes), .big_is_b(big_is_b)
   );

   amap_route #(.CAP_W(CAP_W), .UNIT_SHIFT(UNIT_SHIFT), .LINE_W(LINE_W)) u_route (
      .mode(map_mode_e'(cfg_mode)), .addr(req_addr),
      .a_bytes(a_bytes), .min_bytes(min_bytes), .ilv_bytes(ilv_bytes),
      .sum_bytes(sum_bytes), .big_is_b(big_is_b),
      .sel_a(c_sel_a), .sel_b(c_sel_b), .oor(c_oor), .loc(c_loc)
   );

   assign pay_in = {c_sel_a, c_sel_b, c_oor, c_loc};

   amap_out_stage #(.DATA_W(PAY_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
      .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
   );

   assign {rsp_sel_a, rsp_sel_b, rsp_oor, rsp_local} = pay_out;

   assert_sel_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0({rsp_sel_a, rsp_sel_b}) && (rsp_oor == !(rsp_sel_a || rsp_sel_b)));
   assert_loc_in_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && c_sel_a |-> ({1'b0, c_loc} < a_bytes));
   assert_loc_in_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && c_sel_b |-> ({1'b0, c_loc} < b_bytes));
   assert_oor_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_oor |-> (rsp_local == '0));
endmodule

// File: tb/tb_amap_top.sv
`timescale 1ns/1ps
module tb_amap_top;
   localparam int CAP_W = 2, UNIT_SHIFT = 7, LINE_W = 6;
   localparam int ADDR_W = CAP_W + 1 + UNIT_SHIFT;
   localparam int LOC_W = CAP_W + UNIT_SHIFT;
   localparam int UNIT = 1 << UNIT_SHIFT;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic [CAP_W-1:0] cfg_cap_a = '0, cfg_cap_b = '0;
   logic req_valid = 1'b0, rsp_ready = 1'b1;
   logic [ADDR_W-1:0] req_addr = '0;
   logic req_ready, rsp_valid, rsp_sel_a, rsp_sel_b, rsp_oor;
   logic [LOC_W-1:0] rsp_local;
   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   amap_top #(.CAP_W(CAP_W), .UNIT_SHIFT(UNIT_SHIFT), .LINE_W(LINE_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cap_a(cfg_cap_a),
      .cfg_cap_b(cfg_cap_b), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_sel_a(rsp_sel_a), .rsp_sel_b(rsp_sel_b), .rsp_oor(rsp_oor),
      .rsp_local(rsp_local)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Packs {valid, sel_a, sel_b, oor, local} for one compare.
   function automatic int pack(input int v, input int a, input int b, input int o, input int l);
      return (v << 16) | (a << 15) | (b << 14) | (o << 13) | l;
   endfunction

   function automatic int expect_map(input int m, input int ca, input int cb, input int ad,
                                     output string tag);
      int ua, ub, mn, sm, ch, lc;
      ua = ca * UNIT; ub = cb * UNIT; mn = (ua < ub) ? ua : ub; sm = ua + ub;
      ch = (ad >> LINE_W) & 1;
      lc = ((ad >> (LINE_W + 1)) << LINE_W) | (ad & ((1 << LINE_W) - 1));
      case (m)
         0: begin
            tag = "R4";
            if (ad < 2 * mn) return pack(1, 1 - ch, ch, 0, lc);
            return pack(1, 0, 0, 1, 0);
         end
         1: begin
            tag = (ca == 0 || cb == 0) ? "R8" : "R3";
            if (ad >= sm) begin tag = "R7"; return pack(1, 0, 0, 1, 0); end
            if (ad < ua) return pack(1, 1, 0, 0, ad);
            return pack(1, 0, 1, 0, ad - ua);
         end
         2: begin
            if (ad >= sm) begin tag = "R7"; return pack(1, 0, 0, 1, 0); end
            if (ad < 2 * mn) begin tag = "R5"; return pack(1, 1 - ch, ch, 0, lc); end
            tag = (ca == 0 || cb == 0) ? "R8" : "R6";
            if (ua > ub) return pack(1, 1, 0, 0, ad - mn);
            return pack(1, 0, 1, 0, ad - mn);
         end
         default: begin
            tag = "R9";
            return pack(1, 0, 0, 1, 0);
         end
      endcase
   endfunction

   function automatic int observed();
      return pack(int'(rsp_valid), int'(rsp_sel_a), int'(rsp_sel_b), int'(rsp_oor), int'(rsp_local));
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      string tag;
      int exp;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", int'(rsp_valid), 0);
      check("R1 ready in reset", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", int'(rsp_valid), 0);

      // Exhaustive sweep over modes, capacity pairs and addresses.
      for (int m = 0; m < 4; m++) begin
         for (int ca = 0; ca < 4; ca++) begin
            for (int cb = 0; cb < 4; cb++) begin
               for (int ad = 0; ad < (1 << ADDR_W); ad++) begin
                  cfg_mode = 2'(m); cfg_cap_a = CAP_W'(ca); cfg_cap_b = CAP_W'(cb);
                  req_addr = ADDR_W'(ad); req_valid = 1'b1;
                  @(posedge clk);
                  @(negedge clk);
                  exp = expect_map(m, ca, cb, ad, tag);
                  check(tag, observed(), exp);
               end
            end
         end
      end

      // Backpressure: hold one result while a second request waits.
      req_valid = 1'b0;
      @(negedge clk);
      cfg_mode = 2'b01; cfg_cap_a = 2'd2; cfg_cap_b = 2'd1;
      rsp_ready = 1'b0;
      req_addr = 10'd300; req_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R2 ready low while held", int'(req_ready), 0);
      check("R3 first result", observed(), pack(1, 0, 1, 0, 300 - 256));
      req_addr = 10'd5;
      repeat (3) @(negedge clk);
      check("R2 result held", observed(), pack(1, 0, 1, 0, 300 - 256));
      rsp_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R2 queued taken", observed(), pack(1, 1, 0, 0, 5));
      req_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R2 drained", int'(rsp_valid), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule